// File: doc/BRIEF.md
# Random-Cell Pixel Pattern Generator

This block produces a one-bit-per-pixel blinking pattern for a 64x64 display. The pixel field is treated as 256 short shift registers, each 16 pixels wide and one row tall, with four of them side by side in every row. One long free-running linear feedback shift register (LFSR) supplies the randomness. Each cell is wired to its own bit of that register.

On every frame strobe, each cell shifts by one pixel and takes in the bit from its own LFSR position. Each cell has a fixed shift direction, chosen pseudo-randomly when the design is built. The result is streaks of noise that drift left or right at different places on the display.

A display driver downstream reads the pattern one row at a time through a combinational row port. A seed port lets software restart the random sequence without clearing the picture.

Top module: `cell_pattern_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, every cell is cleared to 0 and the LFSR is loaded with the expansion of parameter `RESET_SEED`. The expansion sets LFSR bit i to seed bit (i mod 32). A seed value of 0 is first replaced by 32'h9E3779B9.
- R2: The LFSR has 4094 bits. When it advances, every bit i moves to i+1 and bit 0 takes the XOR of bits 4093, 4092, 4089 and 4087.
- R3: Cell k reads LFSR bit (k*16 + 3) mod 4094, so the 256 tap positions are all distinct.
- R4: On a clock edge with `frame_tick` high and `seed_load` low, the LFSR advances once. Every cell also shifts once, taking in its tap bit as it was before that edge.
- R5: A left-shifting cell moves bit j to j+1 and takes the tap into bit 0. A right-shifting cell moves bit j to j-1 and takes the tap into bit 15.
- R6: The direction of cell k is fixed at build time from `DIR_SEED`. Start with x = DIR_SEED. For each k = 0,1,2,…, apply one xorshift step to x (x ^= x<<13; x ^= x>>17; x ^= x<<5, all 32-bit); cell k is left-shifting when bit 0 of the result is 1.
- R7: `rd_data` bit c shows pixel column c of row `rd_row`. That pixel is bit (c mod 16) of cell `rd_row`*4 + c/16.
- R8: On an edge with `seed_load` high, the LFSR takes the expansion of `seed_in`, using the same zero substitution as R1. The cells keep their values, even if `frame_tick` is also high.
- R9: On an edge with neither strobe high, the cells and the LFSR hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe that steps the pattern by one frame |
| seed_load | input | 1 | Strobe that reloads the LFSR from `seed_in` |
| seed_in | input | 32 | Seed word that is replicated across the LFSR |
| rd_row | input | 6 | Row to read |
| rd_data | output | 64 | Pixels of the addressed row, column 0 in bit 0 |

## Verification
A frame strobe and a seed reload can arrive in the same cycle. When they do, the reload must win: the LFSR takes the new seed and the cells do not move. The bench drives both strobes together after the pattern has built up, and also part-way through a long run. Every row is then compared against a reference model that applies the reload alone. Further frames then confirm that the LFSR restarted from the new seed rather than from an advanced state.

// File: rtl/cpg_pkg.sv
// Package: shared helper functions for the cell pattern generator.
// Assumes callers pass elaboration-time constants.
package cpg_pkg;

    localparam logic [31:0] ZERO_SEED_SUB = 32'h9E37_79B9;

    // One xorshift step on a 32-bit word.
    function automatic logic [31:0] xs_step(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Direction of cell k: 1 = left, 0 = right (bit 0 after k+1 steps).
    function automatic logic dir_of_cell(input logic [31:0] seed, input int k);
        logic [31:0] x;
        x = seed;
        for (int i = 0; i <= k; i++) x = xs_step(x);
        return x[0];
    endfunction

    // LFSR position feeding cell k.
    function automatic int tap_of_cell(input int k, input int stride,
                                       input int ofs, input int len);
        return (k * stride + ofs) % len;
    endfunction

    // Replace an all-zero seed with a nonzero constant.
    function automatic logic [31:0] fix_seed(input logic [31:0] s);
        return (s == 32'd0) ? ZERO_SEED_SUB : s;
    endfunction

endpackage

// File: rtl/cpg_lfsr.sv
// Module: long Fibonacci LFSR with seed replication.
// Shifts toward the MSB, feedback enters bit 0. A seed load has priority
// over a step. Assumes LEN >= 8.
module cpg_lfsr #(
    parameter int          LEN        = 4094,
    parameter logic [31:0] RESET_SEED = 32'hC0FF_EE11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           load,
    input  logic [31:0]    seed,
    output logic [LEN-1:0] state
);
    import cpg_pkg::*;

    localparam int FB0 = LEN - 1;
    localparam int FB1 = LEN - 2;
    localparam int FB2 = LEN - 5;
    localparam int FB3 = LEN - 7;

    // Replicate a 32-bit seed over the whole register.
    function automatic logic [LEN-1:0] expand(input logic [31:0] s);
        logic [LEN-1:0] v;
        logic [31:0]    f;
        f = fix_seed(s);
        for (int i = 0; i < LEN; i++) v[i] = f[i % 32];
        return v;
    endfunction

    logic fb;

    // Feedback bit from the fixed positions.
    always_comb fb = state[FB0] ^ state[FB1] ^ state[FB2] ^ state[FB3];

    // State update: reset, load, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= expand(RESET_SEED);
        else if (load) state <= expand(seed);
        else if (step) state <= {state[LEN-2:0], fb};
    end

    AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state != '0)); // R8
    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (state[LEN-1:1] == $past(state[LEN-2:0]))); // R2
    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(state)); // R9
endmodule

// File: rtl/cpg_cell.sv
// Module: one pixel cell, a W-bit shift register with a fixed direction.
// LEFT=1 takes the new bit into bit 0, LEFT=0 takes it into bit W-1.
// Assumes W >= 2.
module cpg_cell #(
    parameter int   W    = 16,
    parameter logic LEFT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_next;

    // Next value for the selected direction.
    generate
        if (LEFT) begin : g_left
            always_comb q_next = {q[W-2:0], din};
        end else begin : g_right
            always_comb q_next = {din, q[W-1:1]};
        end
    endgenerate

    // Register: clear on reset, shift when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= q_next;
    end

    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(q)); // R9
    AST_CELL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (LEFT ? q[0] : q[W-1]) == $past(din)); // R5
endmodule

// File: rtl/cpg_row_read.sv
// Module: combinational row selector over the flat cell vector.
// Row r occupies bits [r*ROW_W +: ROW_W], and its lowest cell is in the LSBs.
module cpg_row_read #(
    parameter int ROWS  = 64,
    parameter int ROW_W = 64,
    parameter int AW    = 6
) (
    input  logic [ROWS*ROW_W-1:0] flat,
    input  logic [AW-1:0]         row,
    output logic [ROW_W-1:0]      data
);
    // Slice out the addressed row.
    always_comb data = flat[int'(row)*ROW_W +: ROW_W];
endmodule

// File: rtl/cell_pattern_gen.sv
// Module: top of the random-cell pixel pattern generator.
// One LFSR feeds NCELLS cells, one tap each, and a row port reads them back.
// Assumes frame_tick and seed_load are single-cycle strobes in the clk domain.
module cell_pattern_gen #(
    parameter int          ROWS          = 64,
    parameter int          CELLS_PER_ROW = 4,
    parameter int          CELL_W        = 16,
    parameter int          LFSR_LEN      = 4094,
    parameter int          TAP_STRIDE    = 16,
    parameter int          TAP_OFS       = 3,
    parameter logic [31:0] DIR_SEED      = 32'h1234_5678,
    parameter logic [31:0] RESET_SEED    = 32'hC0FF_EE11
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  frame_tick,
    input  logic                                  seed_load,
    input  logic [31:0]                           seed_in,
    input  logic [$clog2(ROWS)-1:0]               rd_row,
    output logic [CELLS_PER_ROW*CELL_W-1:0]       rd_data
);
    import cpg_pkg::*;

    localparam int NCELLS = ROWS * CELLS_PER_ROW;
    localparam int ROW_W  = CELLS_PER_ROW * CELL_W;
    localparam int AW     = $clog2(ROWS);

    logic [LFSR_LEN-1:0]     lfsr_q;
    logic [NCELLS*CELL_W-1:0] cells;
    logic                    shift_en;

    // Cells move only on a frame strobe that no reload overrides.
    always_comb shift_en = frame_tick && !seed_load;

    cpg_lfsr #(.LEN(LFSR_LEN), .RESET_SEED(RESET_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (frame_tick),
        .load  (seed_load),
        .seed  (seed_in),
        .state (lfsr_q)
    );

    generate
        for (genvar k = 0; k < NCELLS; k++) begin : g_cell
            localparam int   TAP = tap_of_cell(k, TAP_STRIDE, TAP_OFS, LFSR_LEN);
            localparam logic DIR = dir_of_cell(DIR_SEED, k);
            cpg_cell #(.W(CELL_W), .LEFT(DIR)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .shift_en (shift_en),
                .din      (lfsr_q[TAP]),
                .q        (cells[k*CELL_W +: CELL_W])
            );
        end
    endgenerate

    cpg_row_read #(.ROWS(ROWS), .ROW_W(ROW_W), .AW(AW)) u_read (
        .flat (cells),
        .row  (rd_row),
        .data (rd_data)
    );

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && frame_tick) |=> $stable(cells)); // R8
    AST_CLEAR_ON_RST: assert property (@(posedge clk)
        !rst_n |=> (cells == '0)); // R1
endmodule

// File: tb/tb_cell_pattern_gen.sv
module tb_cell_pattern_gen;
    localparam int          ROWS = 64, CPR = 4, CW = 16, LEN = 4094;
    localparam int          NC   = ROWS * CPR;
    localparam logic [31:0] DSEED = 32'h1234_5678;
    localparam logic [31:0] RSEED = 32'hC0FF_EE11;

    logic        clk = 0, rst_n = 0, frame_tick = 0, seed_load = 0;
    logic [31:0] seed_in = 0;
    logic [5:0]  rd_row = 0;
    logic [63:0] rd_data;

    int checks = 0, fails = 0;
    logic [LEN-1:0] m_lfsr;
    logic [CW-1:0]  m_cell [NC];
    logic           m_dir  [NC];

    cell_pattern_gen dut (.clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .seed_load(seed_load), .seed_in(seed_in), .rd_row(rd_row), .rd_data(rd_data));

    always #10 clk = ~clk;

    initial begin
        #(20 * 190000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic [LEN-1:0] m_expand(input logic [31:0] s);
        logic [LEN-1:0] v;
        logic [31:0] f;
        f = (s == 0) ? 32'h9E37_79B9 : s;
        for (int i = 0; i < LEN; i++) v[i] = f[i % 32];
        return v;
    endfunction

    // Reference: a frame step (R2, R3, R4, R5).
    task automatic m_frame();
        for (int k = 0; k < NC; k++) begin
            logic t;
            t = m_lfsr[(k * 16 + 3) % LEN];
            if (m_dir[k]) m_cell[k] = {m_cell[k][CW-2:0], t};
            else          m_cell[k] = {t, m_cell[k][CW-1:1]};
        end
        m_lfsr = {m_lfsr[LEN-2:0],
                  m_lfsr[4093] ^ m_lfsr[4092] ^ m_lfsr[4089] ^ m_lfsr[4087]};
    endtask

    task automatic cycle(input logic tick, input logic load, input logic [31:0] s);
        @(negedge clk);
        frame_tick = tick; seed_load = load; seed_in = s;
        @(negedge clk);
        frame_tick = 0; seed_load = 0;
    endtask

    // Compare every row against the model (R7 mapping).
    task automatic check_all(input string req);
        for (int r = 0; r < ROWS; r++) begin
            logic [63:0] exp;
            for (int c = 0; c < 64; c++) exp[c] = m_cell[r * CPR + c / 16][c % 16];
            rd_row = 6'(r);
            #1;
            checks++;
            if (rd_data !== exp) begin
                fails++;
                $display("FAIL %s row %0d: got %h expected %h", req, r, rd_data, exp);
            end
        end
    endtask

    initial begin
        logic [31:0] x;
        x = DSEED;
        for (int k = 0; k < NC; k++) begin  // R6 direction model
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            m_dir[k] = x[0];
        end
        for (int k = 0; k < NC; k++) m_cell[k] = '0;
        m_lfsr = m_expand(RSEED);

        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R1 reset");

        // One frame from reset: only entry bits can be set (R5, R6).
        cycle(1, 0, 0); m_frame();
        check_all("R5 first frame");

        for (int f = 0; f < 40; f++) begin cycle(1, 0, 0); m_frame(); end
        check_all("R4 after 41 frames");

        cycle(0, 0, 0);
        check_all("R9 idle hold");

        // Both strobes together: reload wins (R8).
        cycle(1, 1, 32'hDEAD_BEEF); m_lfsr = m_expand(32'hDEAD_BEEF);
        check_all("R8 load over tick");
        for (int f = 0; f < 20; f++) begin cycle(1, 0, 0); m_frame(); end
        check_all("R8 restart from seed");

        // Zero seed substitution (R8, R1).
        cycle(0, 1, 32'h0); m_lfsr = m_expand(32'h0);
        check_all("R8 zero seed no shift");
        for (int f = 0; f < 20; f++) begin cycle(1, 0, 0); m_frame(); end
        check_all("R8 zero seed substitute");

        // Long run with gaps and reloads (R2, R3, R4, R9).
        for (int f = 0; f < 1000; f++) begin
            if (f % 97 == 50) begin
                cycle(1, 1, 32'h1000_0001 * f); m_lfsr = m_expand(32'h1000_0001 * f);
            end else if (f % 13 == 0) begin
                cycle(0, 0, 0);
            end else begin
                cycle(1, 0, 0); m_frame();
            end
            check_all("R4 long run");
        end

        // Reset mid-stream clears the picture (R1).
        @(negedge clk); rst_n = 0; frame_tick = 1;
        @(negedge clk); rst_n = 1; frame_tick = 0;
        for (int k = 0; k < NC; k++) m_cell[k] = '0;
        m_lfsr = m_expand(RSEED);
        check_all("R1 mid reset");
        for (int f = 0; f < 5; f++) begin cycle(1, 0, 0); m_frame(); end
        check_all("R1 reseeded sequence");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule